// File: doc/BRIEF.md
# DMA Channel Ring Index Registers

This block holds the ring indexes for a set of DMA channels. Every channel owns two circular rings kept in host memory: a request ring filled by the host and drained by the device, and a response ring filled by the device and drained by the host. Each ring is described by a head index and a tail index. An index counts elements, not bytes. The address of an element is the ring base plus the index times the element size. That arithmetic belongs to the fetch logic, not to this block.

The host reaches the indexes over a simple memory-mapped bus. Each channel has a 4 KB window of its own. The device datapath talks to the block through two valid/ready ports. The consume port advances a channel's request head. It is ready only while that request ring holds at least one entry, so an empty ring applies back-pressure and an offered consume waits. The produce port advances a channel's response tail. It is ready only while that response ring has room, so a full ring stalls the producer until the host frees a slot. A transfer happens in any cycle where valid and ready are both high. The requester holds valid and the channel number steady until that cycle.

The block also decides when to interrupt the host. An interrupt is raised when a produce makes a response ring non-empty, or when a produce carries a force flag while the force enable is set. Plain status lines report, for each channel, whether its request ring is empty and how many entries each ring holds.

Top module: `dma_ring_ptr_regs`

## Requirements
- R1: Host byte address bits [15:12] select the channel and bits [11:0] the offset inside its window. The four registers sit at these offsets: request head at 0x0, request tail at 0x4, response head at 0x8 and response tail at 0xC. Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read is presented. The index is in the low bits and all upper bits are zero.
- R2: After reset every index is zero, every ring is empty, `req_level`/`rsp_level` are zero and `irq_pulse` is low.
- R3: Host writes to request head (0x0) and response tail (0xC) are ignored. Host writes to request tail (0x4) and response head (0x8) replace the index.
- R4: A read of any offset other than the four mapped ones returns zero. A write to such an offset changes no register.
- R5: A host write whose value is DEPTH or more is ignored, and the register keeps its old value.
- R6: `cons_ready` is high exactly when the request ring of `cons_ch` is non-empty. An accepted consume advances that request head by one. The head wraps from DEPTH-1 to 0.
- R7: A ring is full when tail+1 (mod DEPTH) equals head. `prod_ready` is high exactly when the response ring of `prod_ch` is not full. An accepted produce advances that response tail by one, wrapping from DEPTH-1 to 0.
- R8: An accepted produce into a response ring that was empty (head equal to tail) before that cycle gives `irq_pulse` high for exactly the next cycle, with `irq_ch` equal to the channel.
- R9: An accepted produce into a non-empty response ring raises no interrupt, unless `prod_force` is high and `force_en` is high. In that case it pulses as in R8.
- R10: While `force_en` is low, `prod_force` has no effect on `irq_pulse`.
- R11: `req_empty[c]` is high when channel c's request head equals its request tail. `req_level`/`rsp_level` slice c is (tail - head) mod DEPTH for the matching ring.
- R12: Host and device activity on one channel leaves every other channel's indexes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access presented this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Host byte address (channel, offset) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| cons_valid | input | 1 | Device wants to consume one request entry |
| cons_ch | input | 4 | Channel for the consume |
| cons_ready | output | 1 | Request ring of cons_ch is non-empty |
| prod_valid | input | 1 | Device wants to produce one response entry |
| prod_ch | input | 4 | Channel for the produce |
| prod_force | input | 1 | Force-interrupt flag of the completing request |
| prod_ready | output | 1 | Response ring of prod_ch has room |
| force_en | input | 1 | Honour prod_force |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_ch | output | 4 | Channel of the interrupt |
| req_empty | output | 16 | Per-channel request ring empty |
| req_level | output | 64 | Per-channel request occupancy, 4 bits each |
| rsp_level | output | 64 | Per-channel response occupancy, 4 bits each |

## Verification
The interrupt decision is driven with three kinds of produce. Produces into an empty ring should pulse, and produces into a ring that already holds entries should stay silent. Forced produces are tried with the enable both off and on. Together these separate a level-based interrupt from an edge-based one, and a working force override from one that is ignored or always on. Index wrap is tested by filling a ring of non-power-of-two depth until it is full and draining it across the DEPTH-1 to 0 boundary. This catches an off-by-one in the full test and a modulo that assumes a power-of-two depth. Host writes go to read-only, unmapped and out-of-range targets and are read back to confirm they are dropped. Idle channels are read at the end to confirm they were not touched.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int WIN_BITS = 12;

  typedef enum logic [1:0] {
    SLOT_REQ_HEAD = 2'd0,
    SLOT_REQ_TAIL = 2'd1,
    SLOT_RSP_HEAD = 2'd2,
    SLOT_RSP_TAIL = 2'd3
  } ring_slot_e;
endpackage

// File: rtl/ring_index.sv
module ring_index #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             head_adv,
  input  logic             tail_adv,
  input  logic             head_wr,
  input  logic             tail_wr,
  input  logic [IDX_W-1:0] wr_val,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             empty,
  output logic [IDX_W-1:0] level
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] DEP  = IDX_W'(DEPTH);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == LAST) ? '0 : i + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (head_wr)       head <= wr_val;
      else if (head_adv) head <= step(head);
      if (tail_wr)       tail <= wr_val;
      else if (tail_adv) tail <= step(tail);
    end
  end

  assign empty = (head == tail);
  assign level = (tail >= head) ? (tail - head) : (tail + DEP - head);
endmodule

// File: rtl/ring_host_port.sv
module ring_host_port
  import dma_ring_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DEPTH  = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = CH_W + WIN_BITS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  input  logic [NUM_CH-1:0][IDX_W-1:0] req_head,
  input  logic [NUM_CH-1:0][IDX_W-1:0] req_tail,
  input  logic [NUM_CH-1:0][IDX_W-1:0] rsp_head,
  input  logic [NUM_CH-1:0][IDX_W-1:0] rsp_tail,
  output logic [NUM_CH-1:0]            req_tail_wr,
  output logic [NUM_CH-1:0]            rsp_head_wr,
  output logic [IDX_W-1:0]             wr_val,
  output logic [31:0]                  bus_rdata,
  output logic                         bus_rvalid
);
  logic [CH_W-1:0]     ch;
  logic [WIN_BITS-1:0] off;
  logic                mapped;
  logic                in_range;
  ring_slot_e          slot;
  logic [IDX_W-1:0]    rd_idx;

  assign ch       = bus_addr[ADDR_W-1:WIN_BITS];
  assign off      = bus_addr[WIN_BITS-1:0];
  assign mapped   = (off[WIN_BITS-1:4] == '0) && (off[1:0] == 2'b00);
  assign slot     = ring_slot_e'(off[3:2]);
  assign in_range = (bus_wdata < 32'(DEPTH));
  assign wr_val   = bus_wdata[IDX_W-1:0];

  always_comb begin
    req_tail_wr = '0;
    rsp_head_wr = '0;
    if (bus_sel && bus_wr && mapped && in_range) begin
      if (slot == SLOT_REQ_TAIL) req_tail_wr[ch] = 1'b1;
      if (slot == SLOT_RSP_HEAD) rsp_head_wr[ch] = 1'b1;
    end
  end

  always_comb begin
    case (slot)
      SLOT_REQ_HEAD: rd_idx = req_head[ch];
      SLOT_REQ_TAIL: rd_idx = req_tail[ch];
      SLOT_RSP_HEAD: rd_idx = rsp_head[ch];
      default:       rd_idx = rsp_tail[ch];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      bus_rdata  <= (bus_sel && !bus_wr && mapped) ? 32'(rd_idx) : '0;
    end
  end
endmodule

// File: rtl/ring_irq_gate.sv
module ring_irq_gate #(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [CH_W-1:0] push_ch,
  input  logic            was_empty,
  input  logic            force_flag,
  input  logic            force_en,
  output logic            irq_pulse,
  output logic [CH_W-1:0] irq_ch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      irq_ch    <= '0;
    end else begin
      irq_pulse <= push && (was_empty || (force_flag && force_en));
      if (push) irq_ch <= push_ch;
    end
  end
endmodule

// File: rtl/dma_ring_ptr_regs.sv
module dma_ring_ptr_regs
  import dma_ring_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DEPTH  = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = CH_W + WIN_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  input  logic                    cons_valid,
  input  logic [CH_W-1:0]         cons_ch,
  output logic                    cons_ready,
  input  logic                    prod_valid,
  input  logic [CH_W-1:0]         prod_ch,
  input  logic                    prod_force,
  output logic                    prod_ready,
  input  logic                    force_en,
  output logic                    irq_pulse,
  output logic [CH_W-1:0]         irq_ch,
  output logic [NUM_CH-1:0]       req_empty,
  output logic [NUM_CH*IDX_W-1:0] req_level,
  output logic [NUM_CH*IDX_W-1:0] rsp_level
);
  logic [NUM_CH-1:0][IDX_W-1:0] req_head, req_tail, rsp_head, rsp_tail;
  logic [NUM_CH-1:0][IDX_W-1:0] req_lvl, rsp_lvl;
  logic [NUM_CH-1:0]            rsp_empty, rsp_full;
  logic [NUM_CH-1:0]            req_tail_wr, rsp_head_wr;
  logic [NUM_CH-1:0]            pop, push;
  logic [IDX_W-1:0]             wr_val;

  ring_host_port #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_host (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .req_head(req_head), .req_tail(req_tail), .rsp_head(rsp_head), .rsp_tail(rsp_tail),
    .req_tail_wr(req_tail_wr), .rsp_head_wr(rsp_head_wr), .wr_val(wr_val),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  assign cons_ready = !req_empty[cons_ch];
  assign prod_ready = !rsp_full[prod_ch];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign pop[c]  = cons_valid && cons_ready && (cons_ch == CH_W'(c));
    assign push[c] = prod_valid && prod_ready && (prod_ch == CH_W'(c));
    assign rsp_full[c] = (rsp_lvl[c] == IDX_W'(DEPTH - 1));

    ring_index #(.DEPTH(DEPTH)) u_req (
      .clk(clk), .rst_n(rst_n),
      .head_adv(pop[c]), .tail_adv(1'b0),
      .head_wr(1'b0), .tail_wr(req_tail_wr[c]), .wr_val(wr_val),
      .head(req_head[c]), .tail(req_tail[c]),
      .empty(req_empty[c]), .level(req_lvl[c])
    );

    ring_index #(.DEPTH(DEPTH)) u_rsp (
      .clk(clk), .rst_n(rst_n),
      .head_adv(1'b0), .tail_adv(push[c]),
      .head_wr(rsp_head_wr[c]), .tail_wr(1'b0), .wr_val(wr_val),
      .head(rsp_head[c]), .tail(rsp_tail[c]),
      .empty(rsp_empty[c]), .level(rsp_lvl[c])
    );
  end

  assign req_level = req_lvl;
  assign rsp_level = rsp_lvl;

  ring_irq_gate #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .push(|push), .push_ch(prod_ch), .was_empty(rsp_empty[prod_ch]),
    .force_flag(prod_force), .force_en(force_en),
    .irq_pulse(irq_pulse), .irq_ch(irq_ch)
  );
endmodule

// File: rtl/dma_ring_ptr_regs_chk.sv
module dma_ring_ptr_regs_chk #(
  parameter int NUM_CH = 16,
  parameter int DEPTH  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_sel,
  input logic                    bus_wr,
  input logic                    bus_rvalid,
  input logic                    cons_valid,
  input logic [CH_W-1:0]         cons_ch,
  input logic                    cons_ready,
  input logic                    prod_valid,
  input logic [CH_W-1:0]         prod_ch,
  input logic                    prod_force,
  input logic                    prod_ready,
  input logic                    force_en,
  input logic                    irq_pulse,
  input logic [NUM_CH-1:0]       req_empty,
  input logic [NUM_CH*IDX_W-1:0] req_level,
  input logic [NUM_CH*IDX_W-1:0] rsp_level
);
  logic [IDX_W-1:0] req_lvl_c, rsp_lvl_p;
  logic [CH_W-1:0]  cons_ch_q, prod_ch_q;
  logic             host_wr;

  assign req_lvl_c = req_level[cons_ch*IDX_W +: IDX_W];
  assign rsp_lvl_p = rsp_level[prod_ch*IDX_W +: IDX_W];
  assign host_wr   = bus_sel && bus_wr;

  always_ff @(posedge clk) begin
    cons_ch_q <= cons_ch;
    prod_ch_q <= prod_ch;
  end

  // R1
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_sel && !bus_wr));

  // R6
  consume_drops_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && cons_ready && !host_wr) |=>
      req_level[cons_ch_q*IDX_W +: IDX_W] == $past(req_lvl_c) - IDX_W'(1));

  // R7
  produce_adds_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_valid && prod_ready && !host_wr) |=>
      rsp_level[prod_ch_q*IDX_W +: IDX_W] == $past(rsp_lvl_p) + IDX_W'(1));

  // R8
  irq_needs_produce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(prod_valid && prod_ready));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !$past(prod_force && force_en)) |-> $past(rsp_lvl_p == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl
    // R11
    empty_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_empty[c] == (req_level[c*IDX_W +: IDX_W] == '0));
  end
endmodule

bind dma_ring_ptr_regs dma_ring_ptr_regs_chk #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rvalid(bus_rvalid),
  .cons_valid(cons_valid), .cons_ch(cons_ch), .cons_ready(cons_ready),
  .prod_valid(prod_valid), .prod_ch(prod_ch), .prod_force(prod_force), .prod_ready(prod_ready),
  .force_en(force_en), .irq_pulse(irq_pulse),
  .req_empty(req_empty), .req_level(req_level), .rsp_level(rsp_level)
);

// File: tb/dma_ring_ptr_regs_test.sv
module dma_ring_ptr_regs_test;
  localparam int NCH = 16;
  localparam int DEP = 12;
  localparam int IW  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        cons_valid = 1'b0;
  logic [3:0]  cons_ch = '0;
  logic        cons_ready;
  logic        prod_valid = 1'b0;
  logic [3:0]  prod_ch = '0;
  logic        prod_force = 1'b0;
  logic        prod_ready;
  logic        force_en = 1'b0;
  logic        irq_pulse;
  logic [3:0]  irq_ch;
  logic [NCH-1:0]    req_empty;
  logic [NCH*IW-1:0] req_level, rsp_level;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_ring_ptr_regs #(.NUM_CH(NCH), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cons_valid(cons_valid), .cons_ch(cons_ch), .cons_ready(cons_ready),
    .prod_valid(prod_valid), .prod_ch(prod_ch), .prod_force(prod_force), .prod_ready(prod_ready),
    .force_en(force_en), .irq_pulse(irq_pulse), .irq_ch(irq_ch),
    .req_empty(req_empty), .req_level(req_level), .rsp_level(rsp_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int ch, input int off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {4'(ch), 12'(off)}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic host_rd(input int ch, input int off, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {4'(ch), 12'(off)};
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic consume(input int ch, output logic rdy);
    @(negedge clk);
    cons_valid = 1'b1; cons_ch = 4'(ch);
    #1 rdy = cons_ready;
    @(negedge clk);
    cons_valid = 1'b0;
  endtask

  task automatic produce(input int ch, input logic frc, output logic rdy,
                         output logic irq, output logic [3:0] ich);
    @(negedge clk);
    prod_valid = 1'b1; prod_ch = 4'(ch); prod_force = frc;
    #1 rdy = prod_ready;
    @(negedge clk);
    prod_valid = 1'b0; prod_force = 1'b0;
    irq = irq_pulse; ich = irq_ch;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R2 irq low", 32'(irq_pulse), 0);
    chk("R2 req_empty", 32'(req_empty), 32'hFFFF);
    chk("R2 rsp_level", 32'(rsp_level[63:32] | rsp_level[31:0]), 0);
    host_rd(0, 0, d);  chk("R2 ch0 req head", d, 0);
    host_rd(15, 12, d); chk("R2 ch15 rsp tail", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    host_wr(3, 4, 5);
    host_rd(3, 4, d); chk("R1 ch3 req tail", d, 5);
    chk("R11 ch3 req level", 32'(req_level[3*IW +: IW]), 5);
    chk("R11 ch3 not empty", 32'(req_empty[3]), 0);
    host_wr(3, 8, 7);
    host_rd(3, 8, d); chk("R1 ch3 rsp head", d, 7);
    chk("R11 ch3 rsp level", 32'(rsp_level[3*IW +: IW]), 5);
    host_wr(3, 8, 0);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    host_wr(3, 0, 2);
    host_rd(3, 0, d); chk("R3 req head write ignored", d, 0);
    host_wr(3, 12, 4);
    host_rd(3, 12, d); chk("R3 rsp tail write ignored", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    host_wr(3, 16, 9);
    host_rd(3, 16, d);    chk("R4 unmapped read zero", d, 0);
    host_rd(3, 4, d);     chk("R4 unmapped write no effect", d, 5);
    host_rd(3, 12'h7FC, d); chk("R4 high unmapped zero", d, 0);
    host_rd(3, 6, d);     chk("R4 misaligned zero", d, 0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    host_wr(3, 4, DEP);
    host_rd(3, 4, d); chk("R5 out-of-range ignored", d, 5);
    host_wr(3, 4, 32'h1_0002);
    host_rd(3, 4, d); chk("R5 upper bits ignored", d, 5);
    host_wr(3, 4, DEP - 1);
    host_rd(3, 4, d); chk("R5 top index accepted", d, DEP - 1);
  endtask

  task automatic t_consume();
    logic [31:0] d;
    logic rdy;
    int bad = 0;
    consume(5, rdy); chk("R6 empty ring not ready", 32'(rdy), 0);
    host_rd(5, 0, d); chk("R6 head unchanged when empty", d, 0);
    host_wr(5, 4, DEP - 1);
    for (int i = 0; i < DEP - 1; i++) begin
      consume(5, rdy);
      if (!rdy) bad++;
    end
    chk("R6 consumes accepted", bad, 0);
    host_rd(5, 0, d); chk("R6 head advanced", d, DEP - 1);
    chk("R11 ch5 empty", 32'(req_empty[5]), 1);
    host_wr(5, 4, 3);
    chk("R11 ch5 level after wrap tail", 32'(req_level[5*IW +: IW]), 4);
    consume(5, rdy); chk("R6 ready wrap", 32'(rdy), 1);
    host_rd(5, 0, d); chk("R6 head wraps to zero", d, 0);
    chk("R11 ch5 level", 32'(req_level[5*IW +: IW]), 3);
  endtask

  task automatic t_full_irq();
    logic [31:0] d;
    logic rdy, irq;
    logic [3:0] ich;
    int bad = 0;
    for (int i = 0; i < DEP - 1; i++) begin
      produce(7, 1'b0, rdy, irq, ich);
      if (i == 0) begin
        chk("R8 first produce irq", 32'(irq), 1);
        chk("R8 irq channel", 32'(ich), 7);
      end else if (irq || !rdy) bad++;
    end
    chk("R9 no irq on non-empty ring", bad, 0);
    chk("R8 pulse one cycle", 32'(irq_pulse), 0);
    produce(7, 1'b0, rdy, irq, ich);
    chk("R7 full ring stalls", 32'(rdy), 0);
    chk("R7 stalled no irq", 32'(irq), 0);
    host_rd(7, 12, d); chk("R7 tail at top", d, DEP - 1);
    host_wr(7, 8, DEP - 1);
    produce(7, 1'b0, rdy, irq, ich);
    chk("R8 refill irq", 32'(irq), 1);
    chk("R8 refill channel", 32'(ich), 7);
    host_rd(7, 12, d); chk("R7 tail wraps to zero", d, 0);
    chk("R11 ch7 rsp level", 32'(rsp_level[7*IW +: IW]), 1);
  endtask

  task automatic t_force();
    logic rdy, irq;
    logic [3:0] ich;
    produce(9, 1'b0, rdy, irq, ich); chk("R8 ch9 first irq", 32'(irq), 1);
    force_en = 1'b0;
    produce(9, 1'b1, rdy, irq, ich); chk("R10 force ignored when disabled", 32'(irq), 0);
    force_en = 1'b1;
    produce(9, 1'b1, rdy, irq, ich); chk("R9 forced irq", 32'(irq), 1);
    chk("R9 forced irq channel", 32'(ich), 9);
    produce(9, 1'b0, rdy, irq, ich); chk("R9 enable alone no irq", 32'(irq), 0);
    force_en = 1'b0;
  endtask

  task automatic t_isolation();
    logic [31:0] d;
    host_rd(4, 4, d);  chk("R12 ch4 req tail", d, 0);
    host_rd(6, 12, d); chk("R12 ch6 rsp tail", d, 0);
    host_rd(8, 12, d); chk("R12 ch8 rsp tail", d, 0);
    chk("R12 ch4 req empty", 32'(req_empty[4]), 1);
    host_rd(3, 4, d);  chk("R12 ch3 kept", d, DEP - 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_ro();
    t_unmapped();
    t_range();
    t_consume();
    t_full_irq();
    t_force();
    t_isolation();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end
endmodule